// File: doc/BRIEF.md
# Biased Exponent Adder With Constant-Bias Subtractor

This block forms the biased exponent of a single-precision product from the biased exponents of its two factors. The two exponent fields go through a ripple-carry adder, which gives a sum one bit wider than the fields. That sum then goes through a borrow-ripple chain that takes away the constant bias. Each stage of the chain is a reduced subtractor cell. The cell type is picked per bit from the bias constant: one type takes away a constant one, the other a constant zero.

The result, the final borrow and two flags are captured in one output register stage. The final borrow marks an exponent sum too small to hold a biased result. The overflow flag marks a result beyond the largest finite biased exponent. The special-code flag marks an input exponent field that is all zeros or all ones. Normalization from the significand product, and any treatment of subnormals, infinities or NaNs, belong to the surrounding multiplier.

Top module: `exb_exp_adder`

## Requirements
- R1: While rst_ni is low, exp_o, borrow_o, ovf_o and spec_o are all 0. Every other output reflects the inputs sampled at the previous rising edge of clk_i, so latency is one cycle.
- R2: When exp_a_i + exp_b_i >= 127, exp_o equals exp_a_i + exp_b_i - 127 as a 9-bit unsigned value and borrow_o is 0.
- R3: When exp_a_i + exp_b_i < 127, borrow_o is 1 and exp_o holds the 9-bit two's complement of the negative difference, that is exp_a_i + exp_b_i - 127 + 512.
- R4: ovf_o is 1 exactly when borrow_o is 0 and exp_o is greater than 254, which means exp_a_i + exp_b_i > 381.
- R5: spec_o is 1 exactly when either input exponent equals 0 or 255.
- R6: At the boundaries, a sum of 127 gives exp_o = 0 with no borrow. A sum of 126 gives exp_o = 511 with borrow. A sum of 381 gives exp_o = 254 without ovf_o. A sum of 382 gives exp_o = 255 with ovf_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exp_a_i | input | 8 | Biased exponent of first factor |
| exp_b_i | input | 8 | Biased exponent of second factor |
| exp_o | output | 9 | Sum minus bias, 9-bit modular |
| borrow_o | output | 1 | Final borrow: sum below bias |
| ovf_o | output | 1 | Result above largest finite biased exponent |
| spec_o | output | 1 | An input field is all zeros or all ones |

## Verification
The assertions compare each registered output with the inputs seen one edge earlier. They therefore assume the inputs are stable at the sampling edge. They are switched off until one clock has passed out of reset, so the reset-time zeros are never matched against stale inputs. The stimulus changes the inputs only on falling edges and holds each exponent pair for two full cycles. It sweeps every one of the 65536 pairs, so every carry and borrow path through both chains is exercised. Around that sweep it adds directed pairs at the sum boundaries of R6.

// File: rtl/exb_pkg.sv
package exb_pkg;
  localparam int unsigned EXP_W = 8;
  localparam int unsigned BIAS  = 127;

  typedef enum logic {
    CELL_SUB_ZERO = 1'b0,
    CELL_SUB_ONE  = 1'b1
  } sub_cell_e;
endpackage

// File: rtl/exb_rca.sv
module exb_rca #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W:0]   sum_o
);
  logic [W:1]   carry;
  logic [W-1:0] s;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_half
      assign s[i]       = a_i[i] ^ b_i[i];
      assign carry[i+1] = a_i[i] & b_i[i];
    end else begin : g_full
      logic p;
      assign p          = a_i[i] ^ b_i[i];
      assign s[i]       = p ^ carry[i];
      assign carry[i+1] = (p & carry[i]) ^ (a_i[i] & b_i[i]);
    end
  end

  assign sum_o = {carry[W], s};
endmodule

// File: rtl/exb_bias_sub.sv
module exb_bias_sub
  import exb_pkg::*;
#(
  parameter int unsigned W    = 9,
  parameter int unsigned BIAS = 127
) (
  input  logic [W-1:0] min_i,
  output logic [W-1:0] diff_o,
  output logic         borrow_o
);
  localparam logic [W-1:0] K = W'(BIAS);

  logic [W:0] br;
  assign br[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_cell
    if (sub_cell_e'(K[i]) == CELL_SUB_ONE) begin : g_one
      assign diff_o[i] = ~(min_i[i] ^ br[i]);
      assign br[i+1]   = ~min_i[i] | br[i];
    end else begin : g_zero
      assign diff_o[i] = min_i[i] ^ br[i];
      assign br[i+1]   = ~min_i[i] & br[i];
    end
  end

  assign borrow_o = br[W];
endmodule

// File: rtl/exb_exp_adder.sv
module exb_exp_adder
  import exb_pkg::*;
#(
  parameter int unsigned EXP_WIDTH = exb_pkg::EXP_W,
  parameter int unsigned EXP_BIAS  = exb_pkg::BIAS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [EXP_WIDTH-1:0] exp_a_i,
  input  logic [EXP_WIDTH-1:0] exp_b_i,
  output logic [EXP_WIDTH:0]   exp_o,
  output logic                 borrow_o,
  output logic                 ovf_o,
  output logic                 spec_o
);
  localparam int unsigned SUM_W = EXP_WIDTH + 1;
  localparam logic [SUM_W-1:0] MAX_FIN = SUM_W'((2 ** EXP_WIDTH) - 2);

  logic [SUM_W-1:0] sum, diff;
  logic             brw, ovf_d, spec_d;

  exb_rca #(.W(EXP_WIDTH)) i_rca (
    .a_i  (exp_a_i),
    .b_i  (exp_b_i),
    .sum_o(sum)
  );

  exb_bias_sub #(.W(SUM_W), .BIAS(EXP_BIAS)) i_bias_sub (
    .min_i   (sum),
    .diff_o  (diff),
    .borrow_o(brw)
  );

  always_comb begin
    ovf_d  = !brw && (diff > MAX_FIN);
    spec_d = (exp_a_i == '0) || (exp_a_i == '1) ||
             (exp_b_i == '0) || (exp_b_i == '1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_o    <= '0;
      borrow_o <= 1'b0;
      ovf_o    <= 1'b0;
      spec_o   <= 1'b0;
    end else begin
      exp_o    <= diff;
      borrow_o <= brw;
      ovf_o    <= ovf_d;
      spec_o   <= spec_d;
    end
  end

  // assertion enable: one edge past reset so $past refers to live inputs
  logic primed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) primed_q <= 1'b0;
    else         primed_q <= 1'b1;
  end

  assert_result_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    exp_o == SUM_W'(int'($past(exp_a_i)) + int'($past(exp_b_i)) - int'(EXP_BIAS)));

  assert_borrow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    borrow_o == ((int'($past(exp_a_i)) + int'($past(exp_b_i))) < int'(EXP_BIAS)));

  assert_ovf_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    ovf_o |-> (!borrow_o && exp_o > MAX_FIN));

  assert_ovf_sum_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    ovf_o == ((int'($past(exp_a_i)) + int'($past(exp_b_i)))
              > int'(EXP_BIAS) + (2 ** EXP_WIDTH) - 2));

  assert_spec_R5: assert property (@(posedge clk_i) disable iff (!rst_ni || !primed_q)
    $rose(spec_o) |-> ($past(exp_a_i) == '0 || $past(exp_a_i) == '1 ||
                       $past(exp_b_i) == '0 || $past(exp_b_i) == '1));
endmodule

// File: tb/test_exb_exp_adder.sv
module test_exb_exp_adder;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] exp_a_i = '0;
  logic [7:0] exp_b_i = '0;
  logic [8:0] exp_o;
  logic       borrow_o, ovf_o, spec_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  exb_exp_adder i_exb_exp_adder (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .exp_a_i (exp_a_i),
    .exp_b_i (exp_b_i),
    .exp_o   (exp_o),
    .borrow_o(borrow_o),
    .ovf_o   (ovf_o),
    .spec_o  (spec_o)
  );

  task automatic apply(input int a, input int b, input string req);
    int s, d, e_exp;
    bit e_brw, e_ovf, e_spec;
    @(negedge clk_i);
    exp_a_i = 8'(a);
    exp_b_i = 8'(b);
    @(negedge clk_i);
    s      = a + b;
    d      = s - 127;
    e_brw  = (d < 0);
    e_exp  = d & 511;
    e_ovf  = !e_brw && (e_exp > 254);
    e_spec = (a == 0) || (a == 255) || (b == 0) || (b == 255);
    checks++;
    if (exp_o != 9'(e_exp) || borrow_o != e_brw || ovf_o != e_ovf || spec_o != e_spec) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d actual exp=%0d brw=%0b ovf=%0b spec=%0b expected exp=%0d brw=%0b ovf=%0b spec=%0b",
               req, a, b, exp_o, borrow_o, ovf_o, spec_o, e_exp, e_brw, e_ovf, e_spec);
    end
  endtask

  initial begin
    exp_a_i = 8'd200;
    exp_b_i = 8'd200;
    repeat (3) @(negedge clk_i);
    // R1: reset state with nonzero inputs present
    checks++;
    if (exp_o != '0 || borrow_o || ovf_o || spec_o) begin
      errors++;
      $display("FAIL R1 reset actual exp=%0d brw=%0b ovf=%0b spec=%0b expected all 0",
               exp_o, borrow_o, ovf_o, spec_o);
    end
    rst_ni = 1'b1;

    // R6 boundaries, also covering R2 R3 R4
    apply(127, 0, "R6");
    apply(100, 26, "R6");
    apply(200, 181, "R6");
    apply(200, 182, "R6");
    apply(255, 255, "R4");
    apply(0, 0, "R3");
    apply(1, 1, "R3");
    apply(128, 127, "R2");

    // exhaustive sweep, R2 R3 R4 R5
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        apply(a, b, "R2_R3_R4_R5");

    // R1: async reset clears outputs mid-run
    @(negedge clk_i);
    exp_a_i = 8'd255;
    exp_b_i = 8'd255;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    checks++;
    if (exp_o != '0 || borrow_o || ovf_o || spec_o) begin
      errors++;
      $display("FAIL R1 async reset actual exp=%0d brw=%0b ovf=%0b spec=%0b expected all 0",
               exp_o, borrow_o, ovf_o, spec_o);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule